// File: doc/BRIEF.md
# Prioritised ADC Trigger Chain Sequencer

This block turns trigger events into timed bursts of conversion commands for an ADC. There are up to eight trigger groups. Each group has its own priority, chain length, start delay and spacing delay, and each can take its trigger from either a hardware pulse input or a software strobe. When the sequencer is idle it picks the pending group with the highest priority. It waits out that group's start delay and then issues one to eight conversion commands. Every command names an ADC channel and a one-hot command slot.

All delays are counted in ticks of a free-running prescaler. After each conversion completes, the block captures the result together with the group and segment that produced it. It can also raise one of three sticky done flags for that group. The next segment follows either at once (back-to-back) or after the group's spacing delay. A trigger that arrives for the group currently running is refused and sets that group's sticky error flag. A soft-reset input clears all sequencer state for as long as it is held high.

Top module: `adc_chain_seq`

## Requirements
- R1: While idle, the sequencer accepts the pending group with the largest 3-bit priority (7 highest). Among equal priorities the lowest group index wins. A running chain is never interrupted. A trigger becomes pending on the clock edge where it is sampled, and an accepted group starts on the following edge.
- R2: A chain-length field value N (3 bits) produces exactly N+1 conversion commands.
- R3: The prescaler produces one tick every `presc_div`+1 clock cycles, counting from the end of reset. The start and spacing delays count only these ticks.
- R4: After a group is accepted, its first command is issued once its start delay (in ticks) has elapsed. With `presc_div`=0, the command appears start-delay + 3 cycles after the trigger is driven.
- R5: The back-to-back bit of the completed segment decides what happens next. If it is 1, the next command follows 2 cycles after the previous one when the ADC answers in one cycle. If it is 0, the group's spacing delay is inserted, which gives spacing + 3 cycles with `presc_div`=0.
- R6: `cmd_valid` is a one-cycle strobe per segment. It carries the segment's channel and its one-hot slot. The segment field layout is: channel at bits [CHW-1:0], slot at the next 3 bits, done select at the next 2 bits, and the back-to-back bit on top.
- R7: On completion of a segment, the done select value picks which done flag of that group is set: 1 sets done0, 2 sets done1, 3 sets done2, and 0 sets none. Group g's flags sit at `done_flags[3g+2:3g]`.
- R8: A group in hardware mode (`grp_swmode`=0) starts only from `hw_trig` and ignores `sw_trig`. A group in software mode starts only from `sw_trig` and ignores `hw_trig`.
- R9: A trigger for the group that is currently running sets `err_flags` for that group and queues nothing.
- R10: While `soft_rst` is 1, the chain, pending triggers, the prescaler, all flags and the result strobe are cleared.
- R11: One cycle after `conv_done` is sampled in the waiting state, `res_valid` pulses with the group, the segment index and the data.
- R12: Done and error flags are sticky and clear when their `done_clr`/`err_clr` bit is 1. A set in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Held-high clear of all sequencer state |
| presc_div | input | PSW | Tick divider; tick every value+1 cycles |
| grp_prio | input | NGRP*PRIOW | Per-group priority |
| grp_len | input | NGRP*SGW | Per-group chain length minus one |
| grp_swmode | input | NGRP | 1 = software trigger mode |
| grp_init | input | NGRP*DLYW | Per-group start delay in ticks |
| grp_intv | input | NGRP*DLYW | Per-group spacing delay in ticks |
| seg_cfg | input | NGRP*MAXSEG*SEGW | Segment configuration, group-major |
| hw_trig | input | NGRP | Hardware trigger pulses |
| sw_trig | input | NGRP | Software trigger strobes |
| conv_done | input | 1 | ADC conversion finished |
| conv_data | input | DW | ADC result |
| done_clr | input | NGRP*3 | Write-1 clear of done flags |
| err_clr | input | NGRP | Write-1 clear of error flags |
| cmd_valid | output | 1 | Conversion command strobe |
| cmd_chan | output | CHW | Channel of the command |
| cmd_slot | output | NSLOT | One-hot command slot |
| res_valid | output | 1 | Captured result strobe |
| res_group | output | GW | Group of the captured result |
| res_seg | output | SGW | Segment of the captured result |
| res_data | output | DW | Captured result data |
| done_flags | output | NGRP*3 | Sticky done flags |
| err_flags | output | NGRP | Sticky error flags |
| busy | output | 1 | A chain is in progress |

## Verification
The assertions check on every cycle that:
- each command strobe lasts exactly one cycle and occurs only while a chain is active;
- a result strobe always follows a conversion-done input;
- a chain ends only after a completion or a soft reset;
- no sticky flag drops without its clear bit or a soft reset;
- soft reset leaves everything idle.

Only the bench's scenarios can show the arbitration order, including ties and non-pre-emption, and the exact delay and spacing cycle counts under different prescaler settings. The same holds for chain lengths, done-flag routing, mode selection and error on re-trigger, all judged against a behavioural model compared every clock.

// File: rtl/adc_seq_pkg.sv
// Package: shared state encoding and fixed field widths of the chain sequencer.
package adc_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_ISSUE,
        ST_WAIT,
        ST_GAP
    } seq_state_e;

    localparam int DONE_N = 3;   // done flags per group
    localparam int DSEL_W = 2;   // done select field width
endpackage

// File: rtl/seq_tick_div.sv
// Module: free-running prescaler; emits a one-cycle tick every div+1 clocks.
// Assumes: div may change at any time; the phase restarts on reset or clr.
module seq_tick_div #(
    parameter int PSW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [PSW-1:0] div,
    output logic           tick
);
    logic [PSW-1:0] cnt;

    assign tick = (cnt == div);

    // Count cycles and wrap on the tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/seq_pick.sv
// Module: combinational priority picker among requesting groups.
// Assumes: larger priority value wins; ties go to the lowest index.
module seq_pick #(
    parameter int NGRP  = 8,
    parameter int PRIOW = 3,
    localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic [NGRP-1:0]       req,
    input  logic [NGRP*PRIOW-1:0] prio,
    output logic                  gnt_v,
    output logic [GW-1:0]         gnt_idx
);
    logic [PRIOW-1:0] best;

    // Scan upward; a strictly larger priority replaces the current choice.
    always_comb begin
        gnt_v   = 1'b0;
        gnt_idx = '0;
        best    = '0;
        for (int i = 0; i < NGRP; i++) begin
            if (req[i] && (!gnt_v || prio[i*PRIOW +: PRIOW] > best)) begin
                gnt_v   = 1'b1;
                gnt_idx = GW'(i);
                best    = prio[i*PRIOW +: PRIOW];
            end
        end
    end
endmodule

// File: rtl/seq_flags.sv
// Module: bank of sticky flags with write-1 clear; a set beats a clear.
// Assumes: clr_all is a synchronous clear (soft reset).
module seq_flags #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic [N-1:0] set,
    input  logic [N-1:0] wclr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Hold the flag until cleared; a new event wins.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) flags[i] <= 1'b0;
            else if (set[i])       flags[i] <= 1'b1;
            else if (wclr[i])      flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_chain_seq.sv
// Module: prioritised trigger chain sequencer for an ADC command interface.
// Accepts per-group hardware or software triggers. Arbitrates while idle and
// runs a chain of up to MAXSEG timed conversion commands for the winning group.
// Assumes: configuration is stable while a chain that uses it runs; the slot
// field of each segment is one-hot; conv_done answers each command once.
module adc_chain_seq #(
    parameter int NGRP   = 8,
    parameter int MAXSEG = 8,
    parameter int CHW    = 5,
    parameter int NSLOT  = 3,
    parameter int DW     = 12,
    parameter int PRIOW  = 3,
    parameter int DLYW   = 8,
    parameter int PSW    = 8,
    localparam int GW    = (NGRP > 1) ? $clog2(NGRP) : 1,
    localparam int SGW   = (MAXSEG > 1) ? $clog2(MAXSEG) : 1,
    localparam int SEGW  = CHW + NSLOT + adc_seq_pkg::DSEL_W + 1,
    localparam int NDF   = NGRP * adc_seq_pkg::DONE_N
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          soft_rst,
    input  logic [PSW-1:0]                presc_div,
    input  logic [NGRP*PRIOW-1:0]         grp_prio,
    input  logic [NGRP*SGW-1:0]           grp_len,
    input  logic [NGRP-1:0]               grp_swmode,
    input  logic [NGRP*DLYW-1:0]          grp_init,
    input  logic [NGRP*DLYW-1:0]          grp_intv,
    input  logic [NGRP*MAXSEG*SEGW-1:0]   seg_cfg,
    input  logic [NGRP-1:0]               hw_trig,
    input  logic [NGRP-1:0]               sw_trig,
    input  logic                          conv_done,
    input  logic [DW-1:0]                 conv_data,
    input  logic [NDF-1:0]                done_clr,
    input  logic [NGRP-1:0]               err_clr,
    output logic                          cmd_valid,
    output logic [CHW-1:0]                cmd_chan,
    output logic [NSLOT-1:0]              cmd_slot,
    output logic                          res_valid,
    output logic [GW-1:0]                 res_group,
    output logic [SGW-1:0]                res_seg,
    output logic [DW-1:0]                 res_data,
    output logic [NDF-1:0]                done_flags,
    output logic [NGRP-1:0]               err_flags,
    output logic                          busy
);
    import adc_seq_pkg::*;

    localparam int SL_LO  = CHW;
    localparam int DS_LO  = CHW + NSLOT;
    localparam int B2B_B  = CHW + NSLOT + DSEL_W;

    seq_state_e       st;
    logic [GW-1:0]    cur_grp;
    logic [SGW-1:0]   cur_seg;
    logic [DLYW-1:0]  cnt;
    logic [NGRP-1:0]  pend, trig_new, run_hit, take;
    logic [NDF-1:0]   done_set;
    logic [SEGW-1:0]  cur_cfg;
    logic [DSEL_W-1:0] cur_dsel;
    logic             tick, gnt_v, last_seg, seg_end;
    logic [GW-1:0]    gnt_idx;

    seq_tick_div #(.PSW(PSW)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .div(presc_div), .tick(tick)
    );

    seq_pick #(.NGRP(NGRP), .PRIOW(PRIOW)) u_pick (
        .req(pend), .prio(grp_prio), .gnt_v(gnt_v), .gnt_idx(gnt_idx)
    );

    seq_flags #(.N(NDF)) u_done (
        .clk(clk), .rst_n(rst_n), .clr_all(soft_rst),
        .set(done_set), .wclr(done_clr), .flags(done_flags)
    );

    seq_flags #(.N(NGRP)) u_err (
        .clk(clk), .rst_n(rst_n), .clr_all(soft_rst),
        .set(run_hit), .wclr(err_clr), .flags(err_flags)
    );

    // Select the active segment's configuration and decode its fields.
    assign cur_cfg   = seg_cfg[(int'(cur_grp) * MAXSEG + int'(cur_seg)) * SEGW +: SEGW];
    assign cur_dsel  = cur_cfg[DS_LO +: DSEL_W];
    assign cmd_chan  = cur_cfg[CHW-1:0];
    assign cmd_slot  = cur_cfg[SL_LO +: NSLOT];
    assign cmd_valid = (st == ST_ISSUE);
    assign busy      = (st != ST_IDLE);
    assign last_seg  = (cur_seg == grp_len[int'(cur_grp) * SGW +: SGW]);
    assign seg_end   = (st == ST_WAIT) && conv_done;

    // Per-group trigger source selection and refusal of running-group triggers.
    assign trig_new = (grp_swmode & sw_trig) | (~grp_swmode & hw_trig);
    assign run_hit  = busy ? (trig_new & (NGRP'(1) << cur_grp)) : '0;
    assign take     = (!busy && gnt_v) ? (NGRP'(1) << gnt_idx) : '0;

    // Route a finished segment to its selected done flag.
    always_comb begin
        done_set = '0;
        if (seg_end && cur_dsel != '0)
            done_set[int'(cur_grp) * DONE_N + int'(cur_dsel) - 1] = 1'b1;
    end

    // Pending trigger latches: cleared on acceptance, set by fresh triggers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) pend <= '0;
        else                    pend <= (pend & ~take) | (trig_new & ~run_hit);
    end

    // Chain state machine: accept, start delay, issue, wait, spacing delay.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            st      <= ST_IDLE;
            cur_grp <= '0;
            cur_seg <= '0;
            cnt     <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (gnt_v) begin
                    cur_grp <= gnt_idx;
                    cur_seg <= '0;
                    cnt     <= '0;
                    st      <= ST_INIT;
                end
                ST_INIT: begin
                    if (cnt == grp_init[int'(cur_grp) * DLYW +: DLYW]) st <= ST_ISSUE;
                    else if (tick) cnt <= cnt + 1'b1;
                end
                ST_ISSUE: st <= ST_WAIT;
                ST_WAIT: if (conv_done) begin
                    if (last_seg) st <= ST_IDLE;
                    else begin
                        cur_seg <= cur_seg + 1'b1;
                        cnt     <= '0;
                        st      <= cur_cfg[B2B_B] ? ST_ISSUE : ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (cnt == grp_intv[int'(cur_grp) * DLYW +: DLYW]) st <= ST_ISSUE;
                    else if (tick) cnt <= cnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Capture each completed conversion with its group and segment tag.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            res_valid <= 1'b0;
            res_group <= '0;
            res_seg   <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= seg_end;
            if (seg_end) begin
                res_group <= cur_grp;
                res_seg   <= cur_seg;
                res_data  <= conv_data;
            end
        end
    end
endmodule

// File: rtl/adc_chain_seq_chk.sv
// Module: property checker for adc_chain_seq, attached by bind below.
// Assumes: reset is synchronous and active low.
module adc_chain_seq_chk #(
    parameter int NGRP = 8,
    parameter int NDF  = 24
) (
    input logic            clk,
    input logic            rst_n,
    input logic            soft_rst,
    input logic            cmd_valid,
    input logic            busy,
    input logic            conv_done,
    input logic            res_valid,
    input logic [NDF-1:0]  done_flags,
    input logic [NDF-1:0]  done_clr,
    input logic [NGRP-1:0] err_flags,
    input logic [NGRP-1:0] err_clr
);
    // R6: a command strobe lasts one cycle.
    assert_cmd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R6: commands only occur inside a running chain.
    assert_cmd_in_chain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    // R11: a captured result always follows a sampled conversion done.
    assert_res_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(conv_done));

    // R2: a chain ends only on a completion or a soft reset.
    assert_chain_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(conv_done) || $past(soft_rst)));

    // R10: soft reset leaves everything idle and clear.
    assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!busy && !res_valid && err_flags == '0 && done_flags == '0));

    for (genvar g = 0; g < NGRP; g++) begin : g_err
        // R12: an error flag drops only on its clear bit or a soft reset.
        assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(err_flags[g]) |-> ($past(err_clr[g]) || $past(soft_rst)));
    end

    for (genvar d = 0; d < NDF; d++) begin : g_done
        // R12: a done flag drops only on its clear bit or a soft reset.
        assert_done_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(done_flags[d]) |-> ($past(done_clr[d]) || $past(soft_rst)));
    end
endmodule

bind adc_chain_seq adc_chain_seq_chk #(
    .NGRP(NGRP),
    .NDF (NGRP * adc_seq_pkg::DONE_N)
) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_valid(cmd_valid),
    .busy(busy), .conv_done(conv_done), .res_valid(res_valid),
    .done_flags(done_flags), .done_clr(done_clr),
    .err_flags(err_flags), .err_clr(err_clr)
);

// File: tb/adc_chain_seq_test.sv
// Bench: behavioural reference model compared every clock, plus scenarios.
module adc_chain_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 8, NS = 8, CHW = 5, DW = 12;
    localparam int SEGW = CHW + 3 + 2 + 1;
    localparam int WATCHDOG = 100000;

    logic clk = 0, rst_n = 0, soft_rst = 0;
    logic [7:0] presc_div = 0;
    logic [NG*3-1:0] grp_prio, grp_len;
    logic [NG-1:0] grp_swmode = 0, hw_trig = 0, sw_trig = 0, err_clr = 0;
    logic [NG*8-1:0] grp_init, grp_intv;
    logic [NG*NS*SEGW-1:0] seg_cfg;
    logic conv_done = 0;
    logic [DW-1:0] conv_data = 0;
    logic [NG*3-1:0] done_clr = 0;
    logic cmd_valid, res_valid, busy;
    logic [CHW-1:0] cmd_chan;
    logic [2:0] cmd_slot, res_group, res_seg;
    logic [DW-1:0] res_data;
    logic [NG*3-1:0] done_flags;
    logic [NG-1:0] err_flags;

    int c_prio[NG], c_len[NG], c_init[NG], c_intv[NG];
    logic [4:0] s_chan[NG][NS];
    logic [2:0] s_slot[NG][NS];
    logic [1:0] s_dsel[NG][NS];
    logic       s_b2b[NG][NS];

    int checks = 0, errors = 0, cyc = 0, adc_lat = 1, adc_wait = 0;
    int cmd_t[$], cmd_c[$], res_g[$], res_s[$];

    adc_chain_seq uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .presc_div(presc_div),
        .grp_prio(grp_prio), .grp_len(grp_len), .grp_swmode(grp_swmode),
        .grp_init(grp_init), .grp_intv(grp_intv), .seg_cfg(seg_cfg),
        .hw_trig(hw_trig), .sw_trig(sw_trig), .conv_done(conv_done),
        .conv_data(conv_data), .done_clr(done_clr), .err_clr(err_clr),
        .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_slot(cmd_slot),
        .res_valid(res_valid), .res_group(res_group), .res_seg(res_seg),
        .res_data(res_data), .done_flags(done_flags), .err_flags(err_flags),
        .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Configuration tables and their packing onto the ports.
    initial begin
        c_prio = '{0, 3, 5, 2, 6, 1, 6, 7};
        c_len  = '{3, 0, 2, 1, 0, 0, 0, 0};
        c_init = '{1, 0, 2, 0, 0, 0, 0, 0};
        c_intv = '{2, 2, 1, 2, 2, 2, 2, 2};
        for (int g = 0; g < NG; g++)
            for (int s = 0; s < NS; s++) begin
                s_chan[g][s] = 5'((g * 4 + s) % 32);
                s_slot[g][s] = 3'(1 << (s % 3));
                s_dsel[g][s] = 2'(s % 4);
                s_b2b[g][s]  = (s % 2 == 0);
            end
    end

    always_comb begin
        for (int g = 0; g < NG; g++) begin
            grp_prio[g*3 +: 3] = 3'(c_prio[g]);
            grp_len[g*3 +: 3]  = 3'(c_len[g]);
            grp_init[g*8 +: 8] = 8'(c_init[g]);
            grp_intv[g*8 +: 8] = 8'(c_intv[g]);
            for (int s = 0; s < NS; s++)
                seg_cfg[(g*NS + s)*SEGW +: SEGW] = {s_b2b[g][s], s_dsel[g][s], s_slot[g][s], s_chan[g][s]};
        end
    end

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    // Behavioural reference model: phase 0 idle,1 start delay,2 issue,3 wait,4 spacing.
    int m_ph, m_grp, m_seg, m_cnt, m_pc;
    bit m_pend[NG], m_err[NG], m_done[NG*3];
    bit m_rv; int m_rg, m_rs, m_rd;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n || soft_rst) begin
            m_ph = 0; m_grp = 0; m_seg = 0; m_cnt = 0; m_pc = 0; m_rv = 0;
            m_rg = 0; m_rs = 0; m_rd = 0;
            foreach (m_pend[i]) begin m_pend[i] = 0; m_err[i] = 0; end
            foreach (m_done[i]) m_done[i] = 0;
        end else begin
            bit tk; int win; bit tr[NG];
            tk = (m_pc == int'(presc_div));
            win = -1;
            if (m_ph == 0)
                for (int p = 7; p >= 0; p--)
                    for (int g = 0; g < NG; g++)
                        if (win < 0 && m_pend[g] && c_prio[g] == p) win = g;
            foreach (m_err[g]) if (err_clr[g]) m_err[g] = 0;
            foreach (m_done[d]) if (done_clr[d]) m_done[d] = 0;
            if (win >= 0) m_pend[win] = 0;
            for (int g = 0; g < NG; g++) begin
                tr[g] = grp_swmode[g] ? sw_trig[g] : hw_trig[g];
                if (tr[g]) begin
                    if (m_ph != 0 && g == m_grp) m_err[g] = 1;
                    else m_pend[g] = 1;
                end
            end
            m_rv = 0;
            case (m_ph)
                0: if (win >= 0) begin m_grp = win; m_seg = 0; m_cnt = 0; m_ph = 1; end
                1: if (m_cnt == c_init[m_grp]) m_ph = 2; else if (tk) m_cnt++;
                2: m_ph = 3;
                3: if (conv_done) begin
                    m_rv = 1; m_rg = m_grp; m_rs = m_seg; m_rd = int'(conv_data);
                    if (s_dsel[m_grp][m_seg] != 0) m_done[m_grp*3 + int'(s_dsel[m_grp][m_seg]) - 1] = 1;
                    if (m_seg == c_len[m_grp]) m_ph = 0;
                    else begin
                        m_ph = s_b2b[m_grp][m_seg] ? 2 : 4;
                        m_seg++; m_cnt = 0;
                    end
                end
                4: if (m_cnt == c_intv[m_grp]) m_ph = 2; else if (tk) m_cnt++;
                default: m_ph = 0;
            endcase
            m_pc = tk ? 0 : m_pc + 1;
        end
    end

    // Per-cycle comparison, event logging and the ADC responder.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy == (m_ph != 0), "R1 busy vs model", busy, m_ph != 0);
            chk(cmd_valid == (m_ph == 2), "R6 cmd_valid vs model", cmd_valid, m_ph == 2);
            if (m_ph == 2) begin
                chk(cmd_chan == s_chan[m_grp][m_seg], "R6 cmd_chan", cmd_chan, s_chan[m_grp][m_seg]);
                chk(cmd_slot == s_slot[m_grp][m_seg], "R6 cmd_slot", cmd_slot, s_slot[m_grp][m_seg]);
            end
            chk(res_valid == m_rv, "R11 res_valid", res_valid, m_rv);
            if (m_rv) begin
                chk(res_group == 3'(m_rg) && res_seg == 3'(m_rs), "R11 res tag",
                    {res_group, res_seg}, {3'(m_rg), 3'(m_rs)});
                chk(res_data == DW'(m_rd), "R11 res_data", res_data, m_rd);
            end
            for (int g = 0; g < NG; g++)
                chk(err_flags[g] == m_err[g], "R9 err flag", err_flags[g], m_err[g]);
            for (int d = 0; d < NG*3; d++)
                chk(done_flags[d] == m_done[d], "R7 done flag", done_flags[d], m_done[d]);
        end
        if (cmd_valid) begin cmd_t.push_back(cyc); cmd_c.push_back(int'(cmd_chan)); end
        if (res_valid) begin res_g.push_back(int'(res_group)); res_s.push_back(int'(res_seg)); end
        conv_done <= 0;
        if (adc_wait > 0) begin
            adc_wait--;
            if (adc_wait == 0) begin conv_done <= 1; conv_data <= DW'(cyc * 7 + 3); end
        end
        if (cmd_valid) adc_wait = adc_lat;
    end

    always @(posedge clk) if (cyc == WATCHDOG) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic clear_logs();
        cmd_t.delete(); cmd_c.delete(); res_g.delete(); res_s.delete();
    endtask

    task automatic pulse_hw(input logic [NG-1:0] m);
        @(negedge clk); hw_trig = m;
        @(negedge clk); hw_trig = 0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        while (q < 4) begin
            @(negedge clk);
            if (busy) q = 0; else q++;
        end
    endtask

    initial begin
        int t0, n0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done_flags == 0 && err_flags == 0 && res_valid == 0,
            "R10 reset state", {busy, res_valid}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // R2 R4 R5 R6 R7: group 2, three segments, tick every cycle.
        clear_logs();
        @(negedge clk); hw_trig = 8'h04; t0 = cyc;
        @(negedge clk); hw_trig = 0;
        wait_quiet();
        chk(cmd_t.size() == 3, "R2 segment count for length 2", cmd_t.size(), 3);
        if (cmd_t.size() == 3) begin
            chk(cmd_t[0] - t0 == 5, "R4 first command latency", cmd_t[0] - t0, 5);
            chk(cmd_t[1] - cmd_t[0] == 2, "R5 back-to-back spacing", cmd_t[1] - cmd_t[0], 2);
            chk(cmd_t[2] - cmd_t[1] == 4, "R5 interval spacing", cmd_t[2] - cmd_t[1], 4);
            chk(cmd_c[2] == int'(s_chan[2][2]), "R6 third channel", cmd_c[2], s_chan[2][2]);
        end
        chk(done_flags[8:6] == 3'b011, "R7 done routing group2", done_flags[8:6], 3);

        // R12: write-1 clear of the done flags.
        @(negedge clk); done_clr = 24'h1C0;
        @(negedge clk); done_clr = 0;
        chk(done_flags[8:6] == 3'b000, "R12 done clear", done_flags[8:6], 0);

        // R1: simultaneous requests, order by priority then index.
        clear_logs();
        pulse_hw(8'h52);
        wait_quiet();
        chk(res_g.size() == 3, "R1 three chains served", res_g.size(), 3);
        if (res_g.size() == 3)
            chk(res_g[0] == 4 && res_g[1] == 6 && res_g[2] == 1, "R1 service order",
                res_g[0]*100 + res_g[1]*10 + res_g[2], 461);

        // R1: no pre-emption of a low-priority chain.
        clear_logs();
        pulse_hw(8'h01);
        repeat (2) @(negedge clk);
        pulse_hw(8'h80);
        wait_quiet();
        n0 = 0;
        foreach (res_g[i]) if (res_g[i] == 0 && (i == 0 || res_g[i-1] == 0)) n0++;
        chk(res_g.size() == 5 && n0 == 4 && res_g[4] == 7, "R1 group0 finishes before group7",
            n0, 4);

        // R9: re-trigger of the running group is refused and flagged.
        clear_logs();
        pulse_hw(8'h01);
        repeat (3) @(negedge clk);
        pulse_hw(8'h01);
        chk(err_flags[0] == 1, "R9 error on re-trigger", err_flags[0], 1);
        wait_quiet();
        chk(res_g.size() == 4, "R9 refused trigger starts no chain", res_g.size(), 4);
        @(negedge clk); err_clr = 8'h01;
        @(negedge clk); err_clr = 0;
        chk(err_flags[0] == 0, "R12 error clear", err_flags[0], 0);

        // R8: software-mode group ignores hardware pulse and vice versa.
        adc_lat = 3;
        grp_swmode = 8'h08;
        clear_logs();
        pulse_hw(8'h08);
        @(negedge clk); sw_trig = 8'h20;
        @(negedge clk); sw_trig = 0;
        repeat (6) @(negedge clk);
        chk(cmd_t.size() == 0 && busy == 0, "R8 wrong-source triggers ignored", cmd_t.size(), 0);
        @(negedge clk); sw_trig = 8'h08;
        @(negedge clk); sw_trig = 0;
        wait_quiet();
        chk(res_g.size() == 2, "R8 software trigger runs chain", res_g.size(), 2);
        adc_lat = 1;

        // R10 then R3: soft reset mid-chain, then latency with a divided tick.
        presc_div = 3;
        pulse_hw(8'h01);
        repeat (4) @(negedge clk);
        soft_rst = 1;
        @(negedge clk);
        chk(busy == 0 && err_flags == 0 && done_flags == 0, "R10 soft reset clears",
            busy, 0);
        clear_logs();
        soft_rst = 0; hw_trig = 8'h04; t0 = cyc;
        @(negedge clk); hw_trig = 0;
        wait_quiet();
        chk(cmd_t.size() == 3, "R3 chain completes with divided tick", cmd_t.size(), 3);
        if (cmd_t.size() > 0)
            chk(cmd_t[0] - t0 == 9, "R3 start delay counts prescaled ticks", cmd_t[0] - t0, 9);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule